// File: doc/BRIEF.md
# High-Speed Direct-Transition Sequencer

This block steers a microcontroller's system clock from either the divided medium-speed active mode or the subclock-driven active mode straight into the high-speed active mode, when the CPU executes its sleep instruction. Five control bits decide whether that request is a legal direct transition: a standby select, a low-speed enable, a medium-speed enable, a direct-transition enable and a timer-side enable. When the request is legal, the block stalls the CPU and runs three timed phases. The first is the sleep-instruction phase of three states, timed in the old clock. Next, on the subclock path only, an oscillator settling wait is chosen by a 3-bit code and timed in the new clock. Last come fourteen exception-handling states, timed in the new clock. The final state of that last phase is flagged by a done pulse.

The block runs on the oscillator clock, so every state is a fixed number of oscillator periods. A high-speed state lasts `HIGH_STATE_OSC` periods, a medium-speed state lasts `MED_STATE_OSC` periods and a subclock state lasts `SUB_STATE_OSC` periods. An elapsed counter records the length of the last transition in oscillator periods. A separate load strobe sets the current mode while the block is idle; this stands in for the mode entries handled elsewhere in the chip.

The controller has five states. `ST_IDLE` waits for a request. `ST_INSTR` times the sleep-instruction states. `ST_SETTLE` times the oscillator wait. `ST_VECTOR` times the first thirteen exception states. `ST_FINISH` times the last exception state and drives the done pulse. Each legal transition follows one of two paths:
- From medium speed: `ST_IDLE` → `ST_INSTR` → `ST_VECTOR` → `ST_FINISH` → `ST_IDLE`.
- From the subclock: `ST_IDLE` → `ST_INSTR` → `ST_SETTLE` → `ST_VECTOR` → `ST_FINISH` → `ST_IDLE`.

Top module: `fmseq_top`

## Requirements
- R1: With the current mode medium speed (clk_sel=1), a request is accepted when cfg_standby=0, cfg_low_on=0, cfg_med_on=0 and cfg_direct=1; cfg_timer_en is don't-care.
- R2: With the current mode subclock (clk_sel=2), a request is accepted only when cfg_standby=1, cfg_low_on=0, cfg_med_on=0, cfg_direct=1 and cfg_timer_en=1.
- R3: After acceptance, clk_sel keeps the old mode for 3 old-clock states (3×MED_STATE_OSC or 3×SUB_STATE_OSC cycles) and then reads 0 (high speed) for the rest of the transition.
- R4: On the subclock path only, a settling wait of W high-speed states follows, where W is taken from cfg_wait_code (sampled at acceptance) as 0:8192, 1:16384, 2:32768, 3:65536, 4:131072, 5:1024, 6:128, 7:16.
- R5: The exception phase lasts 14 high-speed states. done_pulse is high during exactly the last of them (HIGH_STATE_OSC cycles), with clk_sel=0.
- R6: cpu_stall rises in the cycle after the accepting edge and stays high for exactly T cycles. T = 3×pre + 28 for the medium path (76 with defaults) and 3×pre + 2×(W+14) for the subclock path.
- R7: elapsed is cleared at acceptance and counts stalled cycles, so after cpu_stall falls it reads T. It does not change while idle.
- R8: Any other request, including every request while clk_sel=0, raises unsupported for one cycle and leaves clk_sel and cpu_stall unchanged.
- R9: A sleep_req during a transition is ignored: T is unchanged and unsupported stays low.
- R10: While idle and with no sleep_req, mode_set loads clk_sel from mode_set_val (0 high, 1 medium, 2 subclock). The value 3 is ignored. Reset gives clk_sel=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Sleep-instruction strobe |
| cfg_standby | input | 1 | Standby select bit |
| cfg_low_on | input | 1 | Low-speed enable bit |
| cfg_med_on | input | 1 | Medium-speed enable bit |
| cfg_direct | input | 1 | Direct-transition enable bit |
| cfg_timer_en | input | 1 | Timer-side enable bit |
| cfg_wait_code | input | 3 | Oscillator settling wait code |
| mode_set | input | 1 | Load strobe for the current mode |
| mode_set_val | input | 2 | Mode value to load |
| clk_sel | output | 2 | Current clock mode (0 high, 1 medium, 2 subclock) |
| cpu_stall | output | 1 | CPU held during a transition |
| done_pulse | output | 1 | Last exception state |
| unsupported | output | 1 | One-cycle flag for a rejected request |
| elapsed | output | ELAPSED_W | Oscillator periods of the last transition |

## Verification
The edge that samples sleep_req decides everything, so the bench drives its stimulus on falling edges and reads results on the next falling edge. cpu_stall and unsupported are due one cycle after that edge, and unsupported is gone again one cycle later. From then on the bench counts falling edges while cpu_stall is high. The switch of clk_sel to 0 is expected at count 3×pre, done_pulse at counts T−2 and T−1 (with the defaults), and elapsed, read on the first idle falling edge, must equal T. Each expected T is computed from the state counts and the wait-code table.

// File: rtl/fmseq_pkg.sv
package fmseq_pkg;

    typedef enum logic [1:0] {
        CLK_HIGH = 2'd0,
        CLK_MED  = 2'd1,
        CLK_SUB  = 2'd2,
        CLK_RSVD = 2'd3
    } clk_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_INSTR  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_VECTOR = 3'd3,
        ST_FINISH = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        ENTRY_FROM_MED = 2'd0,
        ENTRY_FROM_SUB = 2'd1,
        ENTRY_BAD      = 2'd2
    } entry_e;

    localparam int unsigned SETTLE_MAX = 131072;

    // settling wait in high-speed states per code
    function automatic logic [17:0] settle_states(input logic [2:0] code);
        logic [17:0] r;
        unique case (code)
            3'd0: r = 18'd8192;
            3'd1: r = 18'd16384;
            3'd2: r = 18'd32768;
            3'd3: r = 18'd65536;
            3'd4: r = 18'd131072;
            3'd5: r = 18'd1024;
            3'd6: r = 18'd128;
            default: r = 18'd16;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fmseq_entry_decode.sv
module fmseq_entry_decode
    import fmseq_pkg::*;
(
    input  clk_mode_e mode,
    input  logic      standby,
    input  logic      low_on,
    input  logic      med_on,
    input  logic      direct,
    input  logic      timer_en,
    output entry_e    kind
);
    logic common_ok;

    always_comb begin
        common_ok = !low_on && !med_on && direct;
        kind      = ENTRY_BAD;
        unique case (mode)
            CLK_MED: if (common_ok && !standby)            kind = ENTRY_FROM_MED;
            CLK_SUB: if (common_ok && standby && timer_en) kind = ENTRY_FROM_SUB;
            default: kind = ENTRY_BAD;
        endcase
    end
endmodule

// File: rtl/fmseq_phase_timer.sv
module fmseq_phase_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/fmseq_elapsed.sv
module fmseq_elapsed #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (!rst_n)                    value <= '0;
        else if (clear)                value <= '0;
        else if (inc && (value != '1)) value <= value + 1'b1;
    end
endmodule

// File: rtl/fmseq_top.sv
module fmseq_top
    import fmseq_pkg::*;
#(
    parameter int HIGH_STATE_OSC    = 2,
    parameter int MED_STATE_OSC     = 16,
    parameter int SUB_STATE_OSC     = 64,
    parameter int SLEEP_EXEC_STATES = 2,
    parameter int INTERNAL_STATES   = 1,
    parameter int VECTOR_STATES     = 14,
    parameter int ELAPSED_W         = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sleep_req,
    input  logic                 cfg_standby,
    input  logic                 cfg_low_on,
    input  logic                 cfg_med_on,
    input  logic                 cfg_direct,
    input  logic                 cfg_timer_en,
    input  logic [2:0]           cfg_wait_code,
    input  logic                 mode_set,
    input  logic [1:0]           mode_set_val,
    output logic [1:0]           clk_sel,
    output logic                 cpu_stall,
    output logic                 done_pulse,
    output logic                 unsupported,
    output logic [ELAPSED_W-1:0] elapsed
);
    localparam int PRE_STATES  = SLEEP_EXEC_STATES + INTERNAL_STATES;
    localparam int MAX_PRE_OSC = (MED_STATE_OSC > SUB_STATE_OSC) ? MED_STATE_OSC : SUB_STATE_OSC;
    localparam int MAX_PHASE_A = PRE_STATES * MAX_PRE_OSC;
    localparam int MAX_PHASE_B = SETTLE_MAX * HIGH_STATE_OSC;
    localparam int MAX_PHASE   = (MAX_PHASE_A > MAX_PHASE_B) ? MAX_PHASE_A : MAX_PHASE_B;
    localparam int TIMER_W     = $clog2(MAX_PHASE + 1);

    seq_state_e   state_q, state_d;
    clk_mode_e    mode_q, mode_d;
    entry_e       path_q, path_d, kind;
    logic [2:0]   wait_q, wait_d;
    logic         unsup_q, unsup_d;
    logic         tmr_load, tmr_expired, cnt_clear;
    logic [TIMER_W-1:0] tmr_val, pre_osc;

    fmseq_entry_decode u_decode (
        .mode     (mode_q),
        .standby  (cfg_standby),
        .low_on   (cfg_low_on),
        .med_on   (cfg_med_on),
        .direct   (cfg_direct),
        .timer_en (cfg_timer_en),
        .kind     (kind)
    );

    fmseq_phase_timer #(.W(TIMER_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    fmseq_elapsed #(.W(ELAPSED_W)) u_elapsed (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .inc   (cpu_stall),
        .value (elapsed)
    );

    // next-state logic
    always_comb begin
        state_d   = state_q;
        mode_d    = mode_q;
        path_d    = path_q;
        wait_d    = wait_q;
        unsup_d   = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        cnt_clear = 1'b0;
        pre_osc   = (mode_q == CLK_SUB) ? TIMER_W'(SUB_STATE_OSC) : TIMER_W'(MED_STATE_OSC);
        unique case (state_q)
            ST_IDLE: begin
                if (sleep_req) begin
                    if (kind == ENTRY_BAD) begin
                        unsup_d = 1'b1;
                    end else begin
                        state_d   = ST_INSTR;
                        path_d    = kind;
                        wait_d    = cfg_wait_code;
                        tmr_load  = 1'b1;
                        tmr_val   = TIMER_W'(PRE_STATES) * pre_osc - TIMER_W'(1);
                        cnt_clear = 1'b1;
                    end
                end else if (mode_set && (mode_set_val != CLK_RSVD)) begin
                    mode_d = clk_mode_e'(mode_set_val);
                end
            end
            ST_INSTR: begin
                if (tmr_expired) begin
                    mode_d   = CLK_HIGH;
                    tmr_load = 1'b1;
                    if (path_q == ENTRY_FROM_SUB) begin
                        state_d = ST_SETTLE;
                        tmr_val = TIMER_W'(settle_states(wait_q)) * TIMER_W'(HIGH_STATE_OSC)
                                  - TIMER_W'(1);
                    end else begin
                        state_d = ST_VECTOR;
                        tmr_val = TIMER_W'((VECTOR_STATES - 1) * HIGH_STATE_OSC - 1);
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    state_d  = ST_VECTOR;
                    tmr_load = 1'b1;
                    tmr_val  = TIMER_W'((VECTOR_STATES - 1) * HIGH_STATE_OSC - 1);
                end
            end
            ST_VECTOR: begin
                if (tmr_expired) begin
                    state_d  = ST_FINISH;
                    tmr_load = 1'b1;
                    tmr_val  = TIMER_W'(HIGH_STATE_OSC - 1);
                end
            end
            ST_FINISH: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= CLK_HIGH;
            path_q  <= ENTRY_FROM_MED;
            wait_q  <= 3'd0;
            unsup_q <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            path_q  <= path_d;
            wait_q  <= wait_d;
            unsup_q <= unsup_d;
        end
    end

    // outputs
    always_comb begin
        clk_sel     = mode_q;
        cpu_stall   = (state_q != ST_IDLE);
        done_pulse  = (state_q == ST_FINISH);
        unsupported = unsup_q;
    end
endmodule

// File: rtl/fmseq_top_chk.sv
module fmseq_top_chk #(
    parameter int ELAPSED_W = 20
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sleep_req,
    input logic                 mode_set,
    input logic [1:0]           clk_sel,
    input logic                 cpu_stall,
    input logic                 done_pulse,
    input logic                 unsupported,
    input logic [ELAPSED_W-1:0] elapsed
);
    p_done_in_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> cpu_stall);

    p_stall_ends_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_stall) |-> $past(done_pulse));

    p_done_high_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (clk_sel == 2'd0));

    p_unsup_no_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (!cpu_stall && $past(sleep_req)));

    p_unsup_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> $stable(clk_sel));

    p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stall && $past(cpu_stall)) |-> !unsupported);

    p_elapsed_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stall && !$past(cpu_stall)) |-> $stable(elapsed));

    p_mode_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_sel) |-> (clk_sel == 2'd0 || ($past(mode_set) && !$past(cpu_stall))));
endmodule

bind fmseq_top fmseq_top_chk #(.ELAPSED_W(ELAPSED_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .mode_set    (mode_set),
    .clk_sel     (clk_sel),
    .cpu_stall   (cpu_stall),
    .done_pulse  (done_pulse),
    .unsupported (unsupported),
    .elapsed     (elapsed)
);

// File: tb/fmseq_top_tb_top.sv
module fmseq_top_tb_top;
    localparam int HI  = 2;
    localparam int MED = 16;
    localparam int SUB = 64;
    localparam int EW  = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_req = 1'b0;
    logic [4:0]    cfg = 5'd0;
    logic [2:0]    wcode = 3'd7;
    logic          mode_set = 1'b0;
    logic [1:0]    mode_set_val = 2'd0;
    logic [1:0]    clk_sel;
    logic          cpu_stall, done_pulse, unsupported;
    logic [EW-1:0] elapsed;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fmseq_top #(.HIGH_STATE_OSC(HI), .MED_STATE_OSC(MED), .SUB_STATE_OSC(SUB),
                .ELAPSED_W(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .cfg_standby(cfg[0]), .cfg_low_on(cfg[1]), .cfg_med_on(cfg[2]),
        .cfg_direct(cfg[3]), .cfg_timer_en(cfg[4]), .cfg_wait_code(wcode),
        .mode_set(mode_set), .mode_set_val(mode_set_val),
        .clk_sel(clk_sel), .cpu_stall(cpu_stall), .done_pulse(done_pulse),
        .unsupported(unsupported), .elapsed(elapsed));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int settle(input int code);
        int t [8] = '{8192, 16384, 32768, 65536, 131072, 1024, 128, 16};
        return t[code];
    endfunction

    task automatic set_mode(input int m, input int exp_sel);
        @(negedge clk); mode_set = 1'b1; mode_set_val = 2'(m);
        @(negedge clk); mode_set = 1'b0;
        chk(clk_sel == 2'(exp_sel), "R10", "clk_sel after load", clk_sel, exp_sel);
    endtask

    // issue one request; ok=0 expects rejection
    task automatic run_sleep(input bit ok, input int old_mode, input int pre,
                             input int wait_st, input bit inject, input string req);
        int n = 0, sw = -1, dn = 0, fd = -1, un = 0;
        int t_exp, l1;
        l1 = 3 * pre;
        t_exp = (old_mode == 2) ? l1 + 2 * (wait_st + 14) * HI / 2 : l1 + 14 * HI;
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        if (!ok) begin
            chk(unsupported == 1'b1, "R8", {req, " unsupported"}, unsupported, 1);
            chk(cpu_stall == 1'b0, "R8", {req, " no stall"}, cpu_stall, 0);
            chk(clk_sel == 2'(old_mode), "R8", {req, " mode kept"}, clk_sel, old_mode);
            @(negedge clk);
            chk(unsupported == 1'b0, "R8", {req, " one cycle"}, unsupported, 0);
            return;
        end
        chk(cpu_stall == 1'b1 && unsupported == 1'b0, req, "accepted", cpu_stall, 1);
        while (cpu_stall === 1'b1 && n < 300000) begin
            if (clk_sel == 2'd0 && sw < 0) sw = n;
            if (done_pulse) begin dn++; if (fd < 0) fd = n; end
            if (unsupported) un++;
            sleep_req = inject && (n == 5);
            n++;
            @(negedge clk);
        end
        sleep_req = 1'b0;
        chk(n == t_exp, "R6", {req, " stall length"}, n, t_exp);
        chk(sw == l1, "R3", {req, " switch point"}, sw, l1);
        chk(dn == HI, "R5", {req, " done width"}, dn, HI);
        chk(fd == t_exp - HI, "R5", {req, " done position"}, fd, t_exp - HI);
        chk(elapsed == EW'(t_exp), "R7", {req, " elapsed"}, elapsed, t_exp);
        chk(clk_sel == 2'd0, "R3", {req, " ends high"}, clk_sel, 0);
        if (inject) chk(un == 0, "R9", "no flag while busy", un, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(clk_sel == 2'd0, "R10", "reset clk_sel", clk_sel, 0);
        chk(!cpu_stall && !done_pulse && !unsupported, "R6", "reset outputs", cpu_stall, 0);
        chk(elapsed == '0, "R7", "reset elapsed", elapsed, 0);

        // R10: reserved value ignored
        set_mode(1, 1);
        set_mode(3, 1);

        // R1 sweep from medium speed
        for (int c = 0; c < 32; c++) begin
            bit ok;
            set_mode(1, 1);
            cfg = 5'(c);
            ok = (c[0] == 0) && (c[1] == 0) && (c[2] == 0) && (c[3] == 1);
            run_sleep(ok, 1, MED, 0, 1'b0, "R1");
        end
        // R2 sweep from subclock, wait code 7
        wcode = 3'd7;
        for (int c = 0; c < 32; c++) begin
            bit ok;
            set_mode(2, 2);
            cfg = 5'(c);
            ok = (c == 5'b11001);
            run_sleep(ok, 2, SUB, 16, 1'b0, "R2");
        end
        // R8: high speed rejects every combination
        for (int c = 0; c < 32; c++) begin
            set_mode(0, 0);
            cfg = 5'(c);
            run_sleep(1'b0, 0, HI, 0, 1'b0, "R8");
        end
        // R4: wait codes
        foreach (wcode_list[i]) begin
            set_mode(2, 2);
            cfg = 5'b11001;
            wcode = 3'(wcode_list[i]);
            run_sleep(1'b1, 2, SUB, settle(wcode_list[i]), 1'b0, "R4");
        end
        // R9: request during busy ignored
        set_mode(1, 1);
        cfg = 5'b01000;
        run_sleep(1'b1, 1, MED, 0, 1'b1, "R9");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    int wcode_list [5] = '{6, 5, 0, 1, 2};
endmodule